// File: doc/BRIEF.md
# Two-Tier Interrupt Pending Controller

This block collects interrupt requests from 32 main sources and 11 secondary sources and presents two request lines to a processor: a fast line and a normal line. Each request input has its own attribute bit that makes it either edge-type or level-type. An edge-type input sets its pending bit when it rises. A level-type input keeps its pending bit set for as long as it stays high. When any input goes low, its pending bit is cleared.

Groups of three secondary sources are folded into fixed main sources, through their own mask. Software reaches the block through eight word-addressed 32-bit registers. The pending registers are cleared by writing ones to them. Writes to the configuration registers replace the stored value.

After the secondary sources are folded in, the main pending bits are masked. If any unmasked bit is also routed to the fast line, the fast line asserts and the normal selection is skipped for that evaluation. Otherwise the lowest-numbered unmasked bit is the normal candidate. The held selection, a one-hot word plus the bit number, changes only when it is empty or when the candidate has a lower number than the held bit. The normal line follows that held word.

The block re-evaluates every cycle, so it reacts both to register writes and to input changes. Both outputs update on the clock edge after their cause.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the eight registers read as follows. Main pending, route, selected word and selected index read 0. Main mask reads 0xFFFFFFFF. Level word reads 0x7F. Secondary pending reads 0. Secondary mask reads 0x7FF. Both outputs are low. A register is selected by byte address bits [4:2], with this index map: 0 main pending, 1 route, 2 main mask, 3 level word, 4 selected word, 5 selected index, 6 secondary pending, 7 secondary mask.
- R2: A write to index 0, 4 or 6 clears every bit that is written as 1. A write to index 1, 2, 3 or 7 replaces the stored value. A write to index 5 is ignored.
- R3: When a secondary pending bit is set and its secondary mask bit is clear, it sets a main pending bit: secondary bits 0-2 set main bit 28, bits 3-5 set main bit 23, and bits 6-8 set main bit 15. A set secondary mask bit blocks this.
- R4: When any main bit that is both pending and unmasked has its route bit set to 1, the fast output asserts on the next edge and the held selection does not change. Otherwise the fast output is low.
- R5: In an evaluation without a fast request, the lowest-numbered bit that is pending and unmasked replaces the held selection when the held word is zero or holds a higher-numbered bit. A replacement writes the one-hot bit to index 4 and its number to index 5.
- R6: The normal output is high exactly when the selected word (index 4) is nonzero.
- R7: An edge-type input (attribute 0) sets its pending bit on a rising edge. A software clear of that bit sticks while the input stays high.
- R8: A level-type input (attribute 1) sets its pending bit again in every cycle while it is high, so a software clear does not stick.
- R9: When an input falls, its pending bit and its level record are cleared on the next edge.
- R10: When a new request and a software clear reach the same pending bit in the same cycle, the bit ends up set.
- R11: Reads have no side effects. The read data always shows the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| main_req | input | 32 | Main source request lines |
| main_is_lvl | input | 32 | Per main source: 1 = level-type, 0 = edge-type |
| sub_req | input | 11 | Secondary source request lines |
| sub_is_lvl | input | 11 | Per secondary source: 1 = level-type, 0 = edge-type |
| fiq | output | 1 | Fast interrupt request |
| irq | output | 1 | Normal interrupt request |

## Verification
The interesting collisions are a software write-one-to-clear and a hardware set landing on the same pending bit in the same cycle. The bench provokes this in three ways:
- A level-type input is cleared by software while it stays high.
- A secondary fold keeps re-setting a main bit that software is clearing.
- The rise of an edge-type input coincides with a clear of that same bit.

In each case the pending register must read back set after the edge. A second collision is a fast request arriving while a normal selection is held. The bench checks that the selected word stays unchanged while the fast output rises.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    RG_SRC    = 3'd0,
    RG_ROUTE  = 3'd1,
    RG_MASK   = 3'd2,
    RG_LEVEL  = 3'd3,
    RG_SEL    = 3'd4,
    RG_SELIDX = 3'd5,
    RG_SUB    = 3'd6,
    RG_SUBMSK = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/irqc_req_capture.sv
// Samples request lines; produces rise/fall strobes and the level-hold vector.
module irqc_req_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic [W-1:0] is_lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall,
  output logic [W-1:0] hold
);
  logic [W-1:0] req_q, lvl_q;

  always_comb begin
    rise = req & ~req_q;
    fall = ~req & req_q;
    hold = (lvl_q | (rise & is_lvl)) & req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      lvl_q <= '0;
    end else begin
      req_q <= req;
      lvl_q <= hold;
    end
  end
endmodule

// File: rtl/irqc_fold.sv
// Folds groups of secondary lines onto fixed main bit positions.
module irqc_fold #(
  parameter int          SUB_W  = 11,
  parameter int          MAIN_W = 32,
  parameter int          GRP    = 3,
  parameter int          NGRP   = 3,
  parameter int unsigned TGT [NGRP] = '{28, 23, 15}
) (
  input  logic [SUB_W-1:0]  sub_live,
  output logic [MAIN_W-1:0] main_set
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [MAIN_W-1:0] contrib;
    if (g > 0) begin : g_chain
      assign contrib = g_grp[g-1].contrib |
                       ((MAIN_W'(|sub_live[g*GRP +: GRP])) << TGT[g]);
    end else begin : g_first
      assign contrib = (MAIN_W'(|sub_live[g*GRP +: GRP])) << TGT[g];
    end
  end
  assign main_set = g_grp[NGRP-1].contrib;
endmodule

// File: rtl/irqc_select.sv
// Fast/normal resolution with a sticky lowest-index normal selection.
module irqc_select #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  live,
  input  logic [N-1:0]  route,
  input  logic [N-1:0]  sel_cur,
  input  logic [IW-1:0] idx_cur,
  output logic          fast_hit,
  output logic [N-1:0]  sel_nxt,
  output logic [IW-1:0] idx_nxt
);
  logic [IW-1:0] cand_idx;
  logic [N-1:0]  cand_hot;

  always_comb begin
    cand_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) cand_idx = IW'(i);
    end
    cand_hot = N'(1) << cand_idx;
  end

  always_comb begin
    fast_hit = |(live & route);
    sel_nxt  = sel_cur;
    idx_nxt  = idx_cur;
    if (!fast_hit && (|live)) begin
      if ((sel_cur == '0) || (sel_cur > cand_hot)) begin
        sel_nxt = cand_hot;
        idx_nxt = cand_idx;
      end
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSUB  = 11,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter logic [DW-1:0] LEVEL_RST = 32'h7F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] main_req,
  input  logic [NSRC-1:0] main_is_lvl,
  input  logic [NSUB-1:0] sub_req,
  input  logic [NSUB-1:0] sub_is_lvl,
  output logic            fiq,
  output logic            irq
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] src_q, route_q, mask_q, sel_q;
  logic [DW-1:0]   level_q;
  logic [IW-1:0]   idx_q;
  logic [NSUB-1:0] sub_q, submsk_q;
  logic            fiq_q;

  logic [NSRC-1:0] src_n, route_n, mask_n, sel_n, sel_base, src_pre, fold_set, live;
  logic [DW-1:0]   level_n;
  logic [IW-1:0]   idx_n;
  logic [NSUB-1:0] sub_n, submsk_n, sub_live;
  logic            fast_hit;

  logic [NSRC-1:0] m_rise, m_fall, m_hold;
  logic [NSUB-1:0] s_rise, s_fall, s_hold;

  reg_idx_e  wsel;
  logic      we_src, we_route, we_mask, we_level, we_sel, we_sub, we_submsk;

  assign wsel      = reg_idx_e'(bus_addr[4:2]);
  assign we_src    = bus_wr && (wsel == RG_SRC);
  assign we_route  = bus_wr && (wsel == RG_ROUTE);
  assign we_mask   = bus_wr && (wsel == RG_MASK);
  assign we_level  = bus_wr && (wsel == RG_LEVEL);
  assign we_sel    = bus_wr && (wsel == RG_SEL);
  assign we_sub    = bus_wr && (wsel == RG_SUB);
  assign we_submsk = bus_wr && (wsel == RG_SUBMSK);

  irqc_req_capture #(.W(NSRC)) u_main_cap (
    .clk(clk), .rst_n(rst_n), .req(main_req), .is_lvl(main_is_lvl),
    .rise(m_rise), .fall(m_fall), .hold(m_hold)
  );

  irqc_req_capture #(.W(NSUB)) u_sub_cap (
    .clk(clk), .rst_n(rst_n), .req(sub_req), .is_lvl(sub_is_lvl),
    .rise(s_rise), .fall(s_fall), .hold(s_hold)
  );

  // Software step first, then hardware sets win (R10), then the fold.
  always_comb begin
    route_n  = we_route  ? bus_wdata[NSRC-1:0] : route_q;
    mask_n   = we_mask   ? bus_wdata[NSRC-1:0] : mask_q;
    level_n  = we_level  ? bus_wdata           : level_q;
    submsk_n = we_submsk ? bus_wdata[NSUB-1:0] : submsk_q;
    src_pre  = we_src ? (src_q & ~bus_wdata[NSRC-1:0]) : src_q;
    src_pre  = (src_pre & ~m_fall) | m_rise | m_hold;
    sub_n    = we_sub ? (sub_q & ~bus_wdata[NSUB-1:0]) : sub_q;
    sub_n    = (sub_n & ~s_fall) | s_rise | s_hold;
    sub_live = sub_n & ~submsk_n;
    sel_base = we_sel ? (sel_q & ~bus_wdata[NSRC-1:0]) : sel_q;
  end

  irqc_fold #(.SUB_W(NSUB), .MAIN_W(NSRC)) u_fold (
    .sub_live(sub_live), .main_set(fold_set)
  );

  always_comb begin
    src_n = src_pre | fold_set;
    live  = src_n & ~mask_n;
  end

  irqc_select #(.N(NSRC), .IW(IW)) u_sel (
    .live(live), .route(route_n), .sel_cur(sel_base), .idx_cur(idx_q),
    .fast_hit(fast_hit), .sel_nxt(sel_n), .idx_nxt(idx_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      route_q  <= '0;
      mask_q   <= '1;
      level_q  <= LEVEL_RST;
      sel_q    <= '0;
      idx_q    <= '0;
      sub_q    <= '0;
      submsk_q <= '1;
      fiq_q    <= 1'b0;
    end else begin
      src_q    <= src_n;
      route_q  <= route_n;
      mask_q   <= mask_n;
      level_q  <= level_n;
      sel_q    <= sel_n;
      idx_q    <= idx_n;
      sub_q    <= sub_n;
      submsk_q <= submsk_n;
      fiq_q    <= fast_hit;
    end
  end

  always_comb begin
    unique case (wsel)
      RG_SRC:    bus_rdata = DW'(src_q);
      RG_ROUTE:  bus_rdata = DW'(route_q);
      RG_MASK:   bus_rdata = DW'(mask_q);
      RG_LEVEL:  bus_rdata = level_q;
      RG_SEL:    bus_rdata = DW'(sel_q);
      RG_SELIDX: bus_rdata = DW'(idx_q);
      RG_SUB:    bus_rdata = DW'(sub_q);
      default:   bus_rdata = DW'(submsk_q);
    endcase
  end

  assign fiq = fiq_q;
  assign irq = |sel_q;

  // R5: the held selection is one-hot and agrees with its index
  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));
  p_idx_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != '0) |-> sel_q[idx_q]);
  // R4: a fast request freezes the selection unless software clears it
  p_fast_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_hit && !we_sel) |=> $stable(sel_q));
  // R7: a rising main input is pending after the edge
  p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_rise) |=> ((src_q & $past(m_rise)) == $past(m_rise)));
  // R9: a falling main input is cleared when no fold re-sets it
  p_fall_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|m_fall) && (sub_live == '0)) |=> ((src_q & $past(m_fall)) == '0));
endmodule

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
  localparam int PERIOD = 10;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_MAIN = 2'd2, OP_SUB = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  wreg;
    logic [31:0] data;
    logic [2:0]  chk;
    logic [31:0] exp;
    logic [1:0]  fi;   // {fiq, irq}
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,   3'd2, 32'h0,         3'd2, 32'h0,         2'b00, 4'd2},  // R2 mask replace
    '{OP_MAIN, 3'd0, 32'h0000_0300, 3'd0, 32'h0000_0300, 2'b01, 4'd7},  // R7 edges
    '{OP_RD,   3'd0, 32'h0,         3'd4, 32'h0000_0100, 2'b01, 4'd5},  // R5
    '{OP_RD,   3'd0, 32'h0,         3'd5, 32'd8,         2'b01, 4'd5},  // R5 index
    '{OP_MAIN, 3'd0, 32'h0000_0304, 3'd4, 32'h0000_0004, 2'b01, 4'd5},  // R5 better wins
    '{OP_WR,   3'd5, 32'h1F,        3'd5, 32'd2,         2'b01, 4'd2},  // R2 index write ignored
    '{OP_WR,   3'd0, 32'h4,         3'd0, 32'h0000_0300, 2'b01, 4'd7},  // R7 clear sticks
    '{OP_WR,   3'd4, 32'h4,         3'd4, 32'h0000_0100, 2'b01, 4'd5},  // R5 refill
    '{OP_WR,   3'd0, 32'h300,       3'd0, 32'h0,         2'b01, 4'd6},  // R6
    '{OP_WR,   3'd4, 32'h100,       3'd4, 32'h0,         2'b00, 4'd6},  // R6 irq low
    '{OP_MAIN, 3'd0, 32'h0000_0324, 3'd0, 32'h0000_0020, 2'b01, 4'd8},  // R8 level
    '{OP_WR,   3'd0, 32'h20,        3'd0, 32'h0000_0020, 2'b01, 4'd8},  // R8 clear fails
    '{OP_WR,   3'd1, 32'h20,        3'd4, 32'h0000_0020, 2'b11, 4'd4},  // R4 fast
    '{OP_MAIN, 3'd0, 32'h0000_0304, 3'd0, 32'h0,         2'b01, 4'd9},  // R9 fall
    '{OP_WR,   3'd4, 32'h20,        3'd4, 32'h0,         2'b00, 4'd2},  // R2
    '{OP_WR,   3'd1, 32'h0,         3'd1, 32'h0,         2'b00, 4'd2},  // R2
    '{OP_WR,   3'd7, 32'h7F7,       3'd7, 32'h7F7,       2'b00, 4'd2},  // R2
    '{OP_SUB,  3'd0, 32'h008,       3'd0, 32'h0080_0000, 2'b01, 4'd3},  // R3 fold
    '{OP_RD,   3'd0, 32'h0,         3'd6, 32'h8,         2'b01, 4'd3},  // R3
    '{OP_WR,   3'd0, 32'h0080_0000, 3'd0, 32'h0080_0000, 2'b01, 4'd3},  // R3 re-fold
    '{OP_WR,   3'd6, 32'h8,         3'd6, 32'h0,         2'b01, 4'd2},  // R2
    '{OP_WR,   3'd0, 32'h0080_0000, 3'd0, 32'h0,         2'b01, 4'd3},  // R3
    '{OP_WR,   3'd4, 32'h0080_0000, 3'd5, 32'd23,        2'b00, 4'd5},  // R5
    '{OP_SUB,  3'd0, 32'h009,       3'd0, 32'h0,         2'b00, 4'd3},  // R3 masked
    '{OP_RD,   3'd0, 32'h0,         3'd6, 32'h1,         2'b00, 4'd3}   // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] main_req = '0;
  logic [31:0] main_is_lvl = 32'h0000_0020;
  logic [10:0] sub_req = '0;
  logic [10:0] sub_is_lvl = '0;
  logic        fiq, irq;
  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_pend_ctrl u_irq_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .main_req(main_req),
    .main_is_lvl(main_is_lvl), .sub_req(sub_req), .sub_is_lvl(sub_is_lvl),
    .fiq(fiq), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(logic [2:0] r, string tag, logic [31:0] exp);
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = {r, 2'b00};
    #1 check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    peek(3'd0, "R1 src", 32'h0);
    peek(3'd1, "R1 route", 32'h0);
    peek(3'd2, "R1 mask", 32'hFFFF_FFFF);
    peek(3'd3, "R1 level", 32'h7F);
    peek(3'd4, "R1 sel", 32'h0);
    peek(3'd5, "R1 idx", 32'h0);
    peek(3'd6, "R1 sub", 32'h0);
    peek(3'd7, "R1 submsk", 32'h7FF);
    check("R1 outputs", {30'd0, fiq, irq}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      case (VECS[v].op)
        OP_WR: begin
          bus_addr = {VECS[v].wreg, 2'b00};
          bus_wdata = VECS[v].data;
          bus_wr = 1'b1;
        end
        OP_MAIN: main_req = VECS[v].data;
        OP_SUB:  sub_req = VECS[v].data[10:0];
        default: ;
      endcase
      peek(VECS[v].chk, $sformatf("R%0d vec%0d", VECS[v].rq, v), VECS[v].exp);
      check($sformatf("R%0d vec%0d fiq/irq", VECS[v].rq, v),
            {30'd0, fiq, irq}, {30'd0, VECS[v].fi});
    end

    // R10: edge rise and software clear on the same bit in one cycle
    @(negedge clk);
    main_req = 32'h0000_1304;
    bus_addr = {3'd0, 2'b00};
    bus_wdata = 32'h0000_1000;
    bus_wr = 1'b1;
    peek(3'd0, "R10 set beats clear", 32'h0000_1000);
    peek(3'd4, "R10 selection", 32'h0000_1000);
    check("R6 irq high", {31'd0, irq}, 32'd1);

    // R11: repeated reads leave state intact
    for (int k = 0; k < 3; k++) peek(3'd0, "R11 reread src", 32'h0000_1000);
    peek(3'd4, "R11 reread sel", 32'h0000_1000);

    // R2: level word is stored and read back
    @(negedge clk);
    bus_addr = {3'd3, 2'b00};
    bus_wdata = 32'h55;
    bus_wr = 1'b1;
    peek(3'd3, "R2 level replace", 32'h55);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule